// File: doc/BRIEF.md
# Dual-Mode Receive Block Synchronizer

This block sits in a high-speed serial receive path, directly after the gearbox. It receives one parallel word per clock cycle and finds where each frame starts. A mode input picks the frame length: 66 bits for 10GBASE-R style links or 67 bits for Interlaken style links. The block forms each candidate frame from the current input word and the previous one, starting at a bit offset. When a sync header is bad, the offset moves forward by one bit.

Lock is declared once a run of consecutive good headers reaches a threshold given at run time. Once locked, the block counts bad headers over a fixed window of headers. Too many bad headers in one window drop lock and restart the search. The outputs are the aligned frame, its two-bit header, a frame-valid strobe and the lock flag. In the 67-bit mode the top bit of the frame is passed through unchanged, so a later stage can use it as an inversion flag.

Top module: `dual_mode_block_sync`

## Requirements
- R1: `mode_67`=1 selects 67-bit frames and `mode_67`=0 selects 66-bit frames. In the 66-bit mode, `rx_word[66]` is ignored and `out_word[66]` is 0.
- R2: The header is bits [65:64] of the aligned frame. The values 01 and 10 are valid. The values 00 and 11 are invalid.
- R3: Bits are numbered in arrival order: the previous word's bits 0..len-1 come first, then the current word's bits 0..len-1. The frame taken at offset k is bits k..k+len-1 of that sequence. While searching, an invalid header that is judged moves k forward by one, with len-1 wrapping to 0, and clears the good-header run.
- R4: After each slip, and after each mode change, the next SETTLE (2) frames are not judged.
- R5: `block_lock` rises in the cycle after the judged valid header that brings the consecutive count up to `lock_thresh`. A threshold of 0 or 1 locks on the first valid header.
- R6: While locked, lock drops when ERR_LIMIT invalid headers fall within one window of WIN_LEN headers. The counters then restart, the offset is kept, and the block judges at once.
- R7: When a window of WIN_LEN headers ends below the error limit, the error count restarts from zero.
- R8: `out_word` and `out_hdr` show the aligned frame one cycle after the input word that completes it, with bit 66 intact in the 67-bit mode. `out_valid` equals the previous cycle's lock state, and it is low for the frame formed at a mode change.
- R9: Synchronous reset clears the lock, all counters, the offset, the stored previous word and all outputs to zero.
- R10: A change of `mode_67` while running returns the block to search, with offset 0 and cleared counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_67 | input | 1 | 1: 67-bit frames, 0: 66-bit frames |
| rx_word | input | 67 | Gearbox word, first bit in bit 0 |
| lock_thresh | input | CNT_W | Number of consecutive valid headers needed for lock |
| out_word | output | 67 | Aligned frame, registered |
| out_hdr | output | 2 | Header of the aligned frame, registered |
| out_valid | output | 1 | Frame strobe while locked |
| block_lock | output | 1 | Lock status |

## Verification
The bench builds the block with ERR_LIMIT=3, WIN_LEN=8, SETTLE=2 and CNT_W=8. The short loss window lets a few percent of injected bad headers cause both window restarts and loss of lock within a few hundred cycles. Thresholds from 0 up to 64 exercise both the shortest path to lock and the default lock run. Random starting bit offsets, together with both frame lengths, make the search walk the offset through its wrap point in each mode.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

  localparam int unsigned LEN_SHORT = 66;
  localparam int unsigned LEN_LONG  = 67;
  localparam int unsigned WORD_W    = LEN_LONG;
  localparam int unsigned OFF_W     = $clog2(WORD_W);
  localparam int unsigned HDR_LO    = 64;

  typedef enum logic {ST_SEARCH = 1'b0, ST_LOCKED = 1'b1} bsync_state_e;

  // Frame taken at a bit offset from the pair {current, previous}.
  function automatic logic [WORD_W-1:0] pick_window(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] prev,
    input logic              long_mode,
    input logic [OFF_W-1:0]  off
  );
    logic [2*WORD_W-1:0] strm;
    logic [2*WORD_W-1:0] sh;
    logic [WORD_W-1:0]   res;
    if (long_mode) strm = {cur, prev};
    else           strm = {2'b00, cur[LEN_SHORT-1:0], prev[LEN_SHORT-1:0]};
    sh  = strm >> off;
    res = sh[WORD_W-1:0];
    if (!long_mode) res[WORD_W-1] = 1'b0;
    return res;
  endfunction

  function automatic logic hdr_ok(input logic [1:0] h);
    return h[1] ^ h[0];
  endfunction

  function automatic logic [OFF_W-1:0] next_off(
    input logic [OFF_W-1:0] off,
    input logic             long_mode
  );
    logic [OFF_W-1:0] last;
    last = long_mode ? OFF_W'(LEN_LONG - 1) : OFF_W'(LEN_SHORT - 1);
    return (off >= last) ? '0 : off + OFF_W'(1);
  endfunction

endpackage

// File: rtl/bsync_window.sv
module bsync_window
  import bsync_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              long_mode,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [OFF_W-1:0]  off,
  input  logic              valid_in,
  output logic              hdr_good,
  output logic [WORD_W-1:0] out_word,
  output logic [1:0]        out_hdr,
  output logic              out_valid
);

  logic [WORD_W-1:0] prev_q;
  logic [WORD_W-1:0] win_w;
  logic [1:0]        hdr_w;

  always_comb begin
    win_w    = pick_window(rx_word, prev_q, long_mode, off);
    hdr_w    = win_w[HDR_LO+1:HDR_LO];
    hdr_good = hdr_ok(hdr_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      out_word  <= '0;
      out_hdr   <= '0;
      out_valid <= 1'b0;
    end else begin
      prev_q    <= rx_word;
      out_word  <= win_w;
      out_hdr   <= hdr_w;
      out_valid <= valid_in;
    end
  end

endmodule

// File: rtl/bsync_search.sv
module bsync_search
  import bsync_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned SETTLE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             long_mode,
  input  logic             mode_chg,
  input  logic             hdr_good,
  input  logic [CNT_W-1:0] lock_thresh,
  input  logic             loss,
  output logic             locked,
  output logic [OFF_W-1:0] off,
  output logic             judge_evt,
  output logic             slip_evt,
  output logic             lock_evt
);

  localparam int unsigned SET_W = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);

  bsync_state_e     state_q;
  logic [SET_W-1:0] settle_q;
  logic [CNT_W-1:0] good_q;
  logic [OFF_W-1:0] off_q;
  logic             reach;

  always_comb begin
    judge_evt = (state_q == ST_SEARCH) && (settle_q == '0);
    slip_evt  = judge_evt && !hdr_good;
    reach     = ({1'b0, good_q} + (CNT_W+1)'(1)) >= {1'b0, lock_thresh};
    lock_evt  = judge_evt && hdr_good && reach;
  end

  always_ff @(posedge clk) begin
    if (rst || mode_chg) begin
      state_q  <= ST_SEARCH;
      off_q    <= '0;
      good_q   <= '0;
      settle_q <= rst ? '0 : SET_W'(SETTLE);
    end else begin
      case (state_q)
        ST_SEARCH: begin
          if (settle_q != '0) begin
            settle_q <= settle_q - SET_W'(1);
          end else if (lock_evt) begin
            state_q <= ST_LOCKED;
            good_q  <= '0;
          end else if (hdr_good) begin
            good_q <= good_q + CNT_W'(1);
          end else begin
            off_q    <= next_off(off_q, long_mode);
            good_q   <= '0;
            settle_q <= SET_W'(SETTLE);
          end
        end
        default: begin
          if (loss) begin
            state_q  <= ST_SEARCH;
            good_q   <= '0;
            settle_q <= '0;
          end
        end
      endcase
    end
  end

  assign locked = (state_q == ST_LOCKED);
  assign off    = off_q;

endmodule

// File: rtl/bsync_lossmon.sv
module bsync_lossmon #(
  parameter int unsigned ERR_LIMIT = 16,
  parameter int unsigned WIN_LEN   = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic active,
  input  logic hdr_good,
  output logic loss,
  output logic wrap
);

  localparam int unsigned ERR_W = $clog2(ERR_LIMIT + 1);
  localparam int unsigned WIN_W = $clog2(WIN_LEN + 1);

  logic [ERR_W-1:0] err_q;
  logic [ERR_W-1:0] err_next;
  logic [WIN_W-1:0] win_q;

  always_comb begin
    err_next = err_q + ERR_W'(!hdr_good);
    loss     = active && (err_next >= ERR_W'(ERR_LIMIT));
    wrap     = active && ((win_q + WIN_W'(1)) == WIN_W'(WIN_LEN));
  end

  always_ff @(posedge clk) begin
    if (rst || clr || !active || loss || wrap) begin
      err_q <= '0;
      win_q <= '0;
    end else begin
      err_q <= err_next;
      win_q <= win_q + WIN_W'(1);
    end
  end

endmodule

// File: rtl/dual_mode_block_sync.sv
module dual_mode_block_sync
  import bsync_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned ERR_LIMIT = 16,
  parameter int unsigned WIN_LEN   = 64,
  parameter int unsigned SETTLE    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_67,
  input  logic [WORD_W-1:0] rx_word,
  input  logic [CNT_W-1:0]  lock_thresh,
  output logic [WORD_W-1:0] out_word,
  output logic [1:0]        out_hdr,
  output logic              out_valid,
  output logic              block_lock
);

  logic             mode_q;
  logic             mode_chg;
  logic             hdr_good;
  logic             locked;
  logic [OFF_W-1:0] off;
  logic             judge_evt;
  logic             slip_evt;
  logic             lock_evt;
  logic             loss_evt;
  logic             wrap_evt;
  logic             valid_in;

  always_ff @(posedge clk) begin
    mode_q <= mode_67;
  end

  assign mode_chg = !rst && (mode_67 != mode_q);
  assign valid_in = locked && !mode_chg;

  bsync_window u_window (
    .clk       (clk),
    .rst       (rst),
    .long_mode (mode_67),
    .rx_word   (rx_word),
    .off       (off),
    .valid_in  (valid_in),
    .hdr_good  (hdr_good),
    .out_word  (out_word),
    .out_hdr   (out_hdr),
    .out_valid (out_valid)
  );

  bsync_search #(
    .CNT_W  (CNT_W),
    .SETTLE (SETTLE)
  ) u_search (
    .clk         (clk),
    .rst         (rst),
    .long_mode   (mode_67),
    .mode_chg    (mode_chg),
    .hdr_good    (hdr_good),
    .lock_thresh (lock_thresh),
    .loss        (loss_evt),
    .locked      (locked),
    .off         (off),
    .judge_evt   (judge_evt),
    .slip_evt    (slip_evt),
    .lock_evt    (lock_evt)
  );

  bsync_lossmon #(
    .ERR_LIMIT (ERR_LIMIT),
    .WIN_LEN   (WIN_LEN)
  ) u_lossmon (
    .clk      (clk),
    .rst      (rst),
    .clr      (mode_chg),
    .active   (locked),
    .hdr_good (hdr_good),
    .loss     (loss_evt),
    .wrap     (wrap_evt)
  );

  assign block_lock = locked;

endmodule

// File: rtl/bsync_checker.sv
module bsync_checker
  import bsync_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              mode_67,
  input logic [WORD_W-1:0] out_word,
  input logic              out_valid,
  input logic              block_lock,
  input logic              mode_chg,
  input logic              hdr_good,
  input logic [OFF_W-1:0]  off,
  input logic              judge_evt,
  input logic              slip_evt,
  input logic              lock_evt,
  input logic              loss_evt
);

  p_slip_moves_r3: assert property (@(posedge clk) disable iff (rst)
    slip_evt |=> (off != $past(off)) && !block_lock);

  p_settle_after_slip_r4: assert property (@(posedge clk) disable iff (rst)
    slip_evt |=> !judge_evt);

  p_lock_on_good_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(block_lock) |-> $past(lock_evt && hdr_good));

  p_drop_cause_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(block_lock) && !$past(mode_chg)) |-> $past(loss_evt));

  p_valid_follows_lock_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(block_lock));

  p_short_top_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_67) |-> !out_word[WORD_W-1]);

  p_mode_change_search_r10: assert property (@(posedge clk) disable iff (rst)
    $past(mode_chg) |-> (!block_lock && off == '0));

endmodule

bind dual_mode_block_sync bsync_checker i_bsync_checker (
  .clk        (clk),
  .rst        (rst),
  .mode_67    (mode_67),
  .out_word   (out_word),
  .out_valid  (out_valid),
  .block_lock (block_lock),
  .mode_chg   (mode_chg),
  .hdr_good   (hdr_good),
  .off        (off),
  .judge_evt  (judge_evt),
  .slip_evt   (slip_evt),
  .lock_evt   (lock_evt),
  .loss_evt   (loss_evt)
);

// File: tb/test_dual_mode_block_sync.sv
module test_dual_mode_block_sync;

  localparam int CNT_W  = 8;
  localparam int ERR_L  = 3;
  localparam int WIN_L  = 8;
  localparam int SETTLE = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mode_67 = 1'b0;
  logic [66:0]       rx_word = '0;
  logic [CNT_W-1:0]  lock_thresh = 8'd4;
  logic [66:0]       out_word;
  logic [1:0]        out_hdr;
  logic              out_valid;
  logic              block_lock;

  int checks = 0;
  int fails  = 0;
  int pbad   = 0;
  bit sq[$];

  // reference state
  logic [66:0] m_prev = '0;
  int m_off = 0, m_set = 0, m_good = 0, m_err = 0, m_win = 0;
  bit m_lock = 0, m_modeq = 0;
  logic [66:0] e_word = '0;
  logic [1:0]  e_hdr = '0;
  bit e_valid = 0, e_lock = 0;

  always #5 clk = ~clk;

  dual_mode_block_sync #(
    .CNT_W(CNT_W), .ERR_LIMIT(ERR_L), .WIN_LEN(WIN_L), .SETTLE(SETTLE)
  ) i_dual_mode_block_sync (
    .clk(clk), .rst(rst), .mode_67(mode_67), .rx_word(rx_word),
    .lock_thresh(lock_thresh), .out_word(out_word), .out_hdr(out_hdr),
    .out_valid(out_valid), .block_lock(block_lock)
  );

  task automatic chk(input string req, input logic [66:0] act, input logic [66:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Frame at offset: bit i = arrival bit (off+i) of {prev, cur} (R3, R1)
  function automatic logic [66:0] ref_frame(input logic [66:0] prv, input logic [66:0] cur,
                                             input int off, input int len);
    logic [66:0] f = '0;
    for (int i = 0; i < len; i++) begin
      int idx = off + i;
      f[i] = (idx < len) ? prv[idx] : cur[idx - len];
    end
    return f;
  endfunction

  task automatic model_step();
    int len = mode_67 ? 67 : 66;
    logic [66:0] f = ref_frame(m_prev, rx_word, m_off, len);
    logic [1:0] h = f[65:64];
    bit ok = (h == 2'b01) || (h == 2'b10);
    bit chg = (mode_67 != m_modeq);
    if (rst) begin
      e_word = '0; e_hdr = '0; e_valid = 0;
      m_prev = '0; m_off = 0; m_set = 0; m_good = 0; m_err = 0; m_win = 0;
      m_lock = 0; m_modeq = mode_67; e_lock = 0;
      return;
    end
    e_word = f; e_hdr = h; e_valid = m_lock && !chg;
    m_prev = rx_word; m_modeq = mode_67;
    if (chg) begin
      m_lock = 0; m_off = 0; m_good = 0; m_set = SETTLE; m_err = 0; m_win = 0;
    end else if (!m_lock) begin
      if (m_set > 0) m_set--;
      else if (ok) begin
        if (m_good + 1 >= int'(lock_thresh)) begin m_lock = 1; m_good = 0; end
        else m_good++;
      end else begin
        m_off = (m_off + 1) % len; m_good = 0; m_set = SETTLE;
      end
    end else begin
      int en = m_err + (ok ? 0 : 1);
      if (en >= ERR_L) begin m_lock = 0; m_err = 0; m_win = 0; m_good = 0; m_set = 0; end
      else if (m_win + 1 == WIN_L) begin m_win = 0; m_err = 0; end
      else begin m_win++; m_err = en; end
    end
    e_lock = m_lock;
  endtask

  task automatic push_frame(input int len);
    bit bad = ($urandom % 100) < pbad;
    bit b0 = $urandom % 2;
    for (int i = 0; i < 64; i++) sq.push_back(bit'($urandom % 2));
    sq.push_back(b0);
    sq.push_back(bad ? b0 : ~b0);
    if (len == 67) sq.push_back(bit'($urandom % 2));
  endtask

  task automatic push_junk(input int n);
    for (int i = 0; i < n; i++) sq.push_back(bit'($urandom % 2));
  endtask

  task automatic next_word();
    int len = mode_67 ? 67 : 66;
    logic [66:0] w;
    while (sq.size() < len) push_frame(len);
    for (int i = 0; i < len; i++) w[i] = sq.pop_front();
    if (len == 66) w[66] = bit'($urandom % 2);   // R1: must be ignored
    rx_word = w;
  endtask

  task automatic step(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("R8 R1 word", out_word, e_word);
    chk("R2 hdr", {65'd0, out_hdr}, {65'd0, e_hdr});
    chk("R8 valid", {66'd0, out_valid}, {66'd0, e_valid});
    chk({tag, " lock"}, {66'd0, block_lock}, {66'd0, e_lock});
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      next_word();
      step(tag);
    end
  endtask

  task automatic new_mode(input bit m, input string tag);
    sq.delete();
    mode_67 = m;
    push_junk($urandom % 67);
    run(1, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset state
    rst = 1'b1;
    run(3, "R9");
    chk("R9 reset word", out_word, '0);
    chk("R9 reset lock", {66'd0, block_lock}, '0);
    rst = 1'b0;
    // R3 R4 R5: search from a random bit offset, 66-bit frames
    push_junk($urandom % 66);
    lock_thresh = 8'd4;
    run(400, "R3 R4 R5");
    chk("R5 locked 66", {66'd0, block_lock}, 67'd1);
    // R6 R7: moderate then heavy header errors
    pbad = 10;
    run(400, "R6 R7");
    pbad = 70;
    run(60, "R6");
    chk("R6 lost", {66'd0, block_lock}, 67'd0);
    // R10: switch to 67-bit frames, default threshold of 64
    pbad = 0;
    lock_thresh = 8'd64;
    new_mode(1'b1, "R10");
    run(800, "R10 R5 R3");
    chk("R5 locked 67", {66'd0, block_lock}, 67'd1);
    // R9: reset while locked
    rst = 1'b1;
    run(2, "R9");
    chk("R9 reset clears lock", {66'd0, block_lock}, 67'd0);
    chk("R9 reset clears valid", {66'd0, out_valid}, 67'd0);
    rst = 1'b0;
    // R5: thresholds 0 and 1
    lock_thresh = 8'd0;
    run(400, "R5 thr0");
    chk("R5 thr0 locked", {66'd0, block_lock}, 67'd1);
    lock_thresh = 8'd1;
    new_mode(1'b0, "R10");
    run(400, "R5 thr1");
    // mixed random traffic
    for (int s = 0; s < 30; s++) begin
      if (($urandom % 4) == 0) new_mode(~mode_67, "R10");
      lock_thresh = CNT_W'($urandom % 9);
      pbad = $urandom % 30;
      run(100, "R3 R5 R6 R7");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(10 * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule